// File: doc/BRIEF.md
# Provisional-Write FIFO with Commit and Abort

A single-clock first-in first-out buffer whose writes are provisional. A word pushed with `put` takes a storage slot at once, but the reader cannot see it until the writer confirms it with `commit`. If the writer calls `rollback` instead, every provisional word is dropped and its slots become free for new writes. The writer can therefore stream a packet in and then decide to publish it or discard it, without a separate staging buffer.

The buffer keeps three pointers. The read pointer advances on accepted reads. The published write pointer marks the end of committed data. The provisional write pointer marks the end of all written data. A two-state transaction machine follows whether provisional words exist. It has the states `TXN_IDLE` (no provisional words) and `TXN_OPEN` (provisional words pending). The transition `OPEN_TXN` goes from IDLE to OPEN on an accepted put without commit or rollback. `COMMIT_TXN` goes from OPEN to IDLE on commit, and `ABORT_TXN` goes from OPEN to IDLE on rollback. A put that comes with commit or rollback in IDLE stays in IDLE. The depth parameter is rounded up to a power of two. Two quantized level outputs give pessimistic fill and free-space estimates. Commit and rollback must never be raised in the same cycle.

Top module: `txn_fifo`

## Requirements
- R1: After reset, `valid` and `full` are low, `fill_lvl` is 0, and `space_lvl` is at its maximum code.
- R2: The depth is 2^ceil(log2(MIN_DEPTH)). With MIN_DEPTH=12, exactly 16 puts are accepted before `full` rises.
- R3: Uncommitted words are never readable. `valid` stays low while only provisional words are stored, even when `full` is high.
- R4: `commit` publishes every accepted put since the last commit or rollback, including a put in the same cycle. From the next cycle those words are readable.
- R5: `rollback` discards every accepted put since the last commit or rollback, including a put in the same cycle. It frees their slots, and committed data is left untouched.
- R6: A `put` while `full` is high is ignored. No word is stored and no pointer moves.
- R7: A `got` while `valid` is low is ignored, and the read pointer does not move.
- R8: `fill_lvl` equals floor(C*2^FILL_BITS/DEPTH), saturated at 2^FILL_BITS-1. C is the number of committed, unread words.
- R9: `space_lvl` equals floor(F*2^SPACE_BITS/DEPTH), saturated at 2^SPACE_BITS-1. F is DEPTH minus all stored words, provisional ones included.
- R10: Committed words are read in write order. `rd_data` shows the oldest committed word whenever `valid` is high.
- R11: A level width of 0 removes that indicator, and its 1-bit port is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| put | input | 1 | Write a provisional word |
| wr_data | input | DATA_W | Word to write |
| commit | input | 1 | Publish all provisional words |
| rollback | input | 1 | Discard all provisional words |
| full | output | 1 | No slot free (provisional words count) |
| space_lvl | output | max(SPACE_BITS,1) | Quantized free-space lower bound |
| got | input | 1 | Consume the oldest committed word |
| rd_data | output | DATA_W | Oldest committed word |
| valid | output | 1 | A committed word is available |
| fill_lvl | output | max(FILL_BITS,1) | Quantized committed-fill lower bound |

## Verification
The main instance uses MIN_DEPTH=12, DATA_W=8 and 2-bit indicators. The non-power-of-two request exercises the rounding to 16, and full-while-not-valid is reached within a few cycles. A four-slot instance with both indicator widths set to 0 runs alongside it on the same stimulus to show that the indicators are removed. Random traffic with rare commits and rollbacks walks the pointers through wrap-around and saturation of every level code.

// File: rtl/txn_fifo_pkg.sv
`timescale 1ns/1ps
package txn_fifo_pkg;
    typedef enum logic [0:0] {
        TXN_IDLE = 1'b0,
        TXN_OPEN = 1'b1
    } txn_state_e;
endpackage

// File: rtl/txn_fifo_mem.sv
`timescale 1ns/1ps
module txn_fifo_mem #(
    parameter int AW     = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int SLOTS = 1 << AW;

    logic [DATA_W-1:0] store [SLOTS];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/txn_fifo_ptrs.sv
`timescale 1ns/1ps
module txn_fifo_ptrs
    import txn_fifo_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        put,
    input  logic        got,
    input  logic        commit,
    input  logic        rollback,
    output logic [AW:0] rd_ptr,
    output logic [AW:0] cmt_ptr,
    output logic [AW:0] tmp_ptr,
    output logic        full,
    output logic        valid,
    output logic        put_ok,
    output logic        got_ok,
    output txn_state_e  state
);
    localparam logic [AW:0] DEPTH_P = {1'b1, {AW{1'b0}}};

    txn_state_e state_q, state_d;
    logic [AW:0] occ;
    logic [AW:0] tmp_inc;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TXN_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TXN_IDLE: if (put_ok && !commit && !rollback) state_d = TXN_OPEN;
            TXN_OPEN: if (commit || rollback)             state_d = TXN_IDLE;
            default:                                      state_d = TXN_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        occ    = tmp_ptr - rd_ptr;
        full   = (occ == DEPTH_P);
        valid  = (cmt_ptr != rd_ptr);
        put_ok = put && !full;
        got_ok = got && valid;
    end

    assign tmp_inc = tmp_ptr + {{AW{1'b0}}, put_ok};
    assign state   = state_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr  <= '0;
            cmt_ptr <= '0;
            tmp_ptr <= '0;
        end else begin
            rd_ptr <= rd_ptr + {{AW{1'b0}}, got_ok};
            if (rollback) begin
                tmp_ptr <= cmt_ptr;
            end else begin
                tmp_ptr <= tmp_inc;
            end
            if (commit && !rollback) begin
                cmt_ptr <= tmp_inc;
            end
        end
    end
endmodule

// File: rtl/txn_fifo_level.sv
`timescale 1ns/1ps
module txn_fifo_level #(
    parameter int AW   = 4,
    parameter int BITS = 2,
    parameter int OW   = 2
) (
    input  logic [AW:0]   count,
    output logic [OW-1:0] code
);
    generate
        if (BITS == 0) begin : g_off
            logic unused_cnt;
            assign unused_cnt = ^count;
            assign code       = '0;
        end else begin : g_on
            localparam int SW = AW + 1 + BITS;
            logic [SW-1:0] scaled;
            assign scaled = {count, {BITS{1'b0}}} >> AW;
            assign code   = (scaled >= SW'(1 << BITS)) ? '1 : scaled[OW-1:0];
        end
    endgenerate
endmodule

// File: rtl/txn_fifo.sv
`timescale 1ns/1ps
module txn_fifo
    import txn_fifo_pkg::*;
#(
    parameter int MIN_DEPTH  = 12,
    parameter int DATA_W     = 8,
    parameter int FILL_BITS  = 2,
    parameter int SPACE_BITS = 2
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        put,
    input  logic [DATA_W-1:0]                           wr_data,
    input  logic                                        commit,
    input  logic                                        rollback,
    output logic                                        full,
    output logic [((SPACE_BITS > 0) ? SPACE_BITS : 1)-1:0] space_lvl,
    input  logic                                        got,
    output logic [DATA_W-1:0]                           rd_data,
    output logic                                        valid,
    output logic [((FILL_BITS > 0) ? FILL_BITS : 1)-1:0]  fill_lvl
);
    localparam int AW      = $clog2(MIN_DEPTH);
    localparam int FILL_OW = (FILL_BITS > 0) ? FILL_BITS : 1;
    localparam int SPC_OW  = (SPACE_BITS > 0) ? SPACE_BITS : 1;
    localparam logic [AW:0] DEPTH_P = {1'b1, {AW{1'b0}}};

    logic [AW:0] rd_ptr, cmt_ptr, tmp_ptr;
    logic        put_ok, got_ok;
    txn_state_e  txn_state;
    logic [AW:0] fill_cnt, free_cnt;

    txn_fifo_ptrs #(.AW(AW)) ptrs_i (
        .clk(clk), .rst_n(rst_n), .put(put), .got(got),
        .commit(commit), .rollback(rollback),
        .rd_ptr(rd_ptr), .cmt_ptr(cmt_ptr), .tmp_ptr(tmp_ptr),
        .full(full), .valid(valid), .put_ok(put_ok), .got_ok(got_ok),
        .state(txn_state)
    );

    txn_fifo_mem #(.AW(AW), .DATA_W(DATA_W)) mem_i (
        .clk(clk), .we(put_ok), .waddr(tmp_ptr[AW-1:0]), .wdata(wr_data),
        .raddr(rd_ptr[AW-1:0]), .rdata(rd_data)
    );

    assign fill_cnt = cmt_ptr - rd_ptr;
    assign free_cnt = DEPTH_P - (tmp_ptr - rd_ptr);

    txn_fifo_level #(.AW(AW), .BITS(FILL_BITS), .OW(FILL_OW)) fill_i (
        .count(fill_cnt), .code(fill_lvl)
    );

    txn_fifo_level #(.AW(AW), .BITS(SPACE_BITS), .OW(SPC_OW)) space_i (
        .count(free_cnt), .code(space_lvl)
    );

    logic unused_got_ok;
    assign unused_got_ok = got_ok;
endmodule

// File: rtl/txn_fifo_chk.sv
`timescale 1ns/1ps
module txn_fifo_chk
    import txn_fifo_pkg::*;
#(
    parameter int AW = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        put,
    input logic        got,
    input logic        commit,
    input logic        rollback,
    input logic        full,
    input logic        valid,
    input logic [AW:0] rd_ptr,
    input logic [AW:0] cmt_ptr,
    input logic [AW:0] tmp_ptr,
    input txn_state_e  state
);
    localparam logic [AW:0] DEPTH_P = {1'b1, {AW{1'b0}}};
    logic [AW:0] occ, pub;
    assign occ = tmp_ptr - rd_ptr;
    assign pub = cmt_ptr - rd_ptr;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= DEPTH_P); // R6
    AST_FULL_PUT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (put && full && !commit && !rollback) |=> $stable(tmp_ptr)); // R6
    AST_PUB_WITHIN_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        pub <= occ); // R3
    AST_STATE_MATCHES_PTRS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TXN_IDLE) == (tmp_ptr == cmt_ptr)); // R3
    AST_COMMIT_PUBLISHES: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !rollback) |=> (cmt_ptr == tmp_ptr)); // R4
    AST_ROLLBACK_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        (rollback && !commit) |=> (tmp_ptr == $past(cmt_ptr) && $stable(cmt_ptr))); // R5
    AST_EMPTY_GOT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (got && !valid) |=> $stable(rd_ptr)); // R7
endmodule

bind txn_fifo txn_fifo_chk #(.AW(AW)) chk_i (
    .clk(clk), .rst_n(rst_n), .put(put), .got(got),
    .commit(commit), .rollback(rollback), .full(full), .valid(valid),
    .rd_ptr(rd_ptr), .cmt_ptr(cmt_ptr), .tmp_ptr(tmp_ptr), .state(txn_state)
);

// File: tb/txn_fifo_tb_top.sv
`timescale 1ns/1ps
module txn_fifo_tb_top;
    localparam int DEPTH = 16;
    localparam int BITS  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic put = 0, got = 0, commit = 0, rollback = 0;
    logic [7:0] wr_data = '0;
    logic full, valid;
    logic [1:0] space_lvl, fill_lvl;
    logic [7:0] rd_data;
    logic full0, valid0, space0, fill0;
    logic [7:0] rd_data0;

    int n_chk = 0, n_fail = 0;
    int mrd = 0, mcmt = 0, mtmp = 0;
    logic [7:0] mmem [DEPTH];

    always #5 clk = ~clk;

    txn_fifo #(.MIN_DEPTH(12), .DATA_W(8), .FILL_BITS(2), .SPACE_BITS(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .put(put), .wr_data(wr_data), .commit(commit),
        .rollback(rollback), .full(full), .space_lvl(space_lvl), .got(got),
        .rd_data(rd_data), .valid(valid), .fill_lvl(fill_lvl)
    );

    txn_fifo #(.MIN_DEPTH(4), .DATA_W(8), .FILL_BITS(0), .SPACE_BITS(0)) dut0_i (
        .clk(clk), .rst_n(rst_n), .put(put), .wr_data(wr_data), .commit(commit),
        .rollback(rollback), .full(full0), .space_lvl(space0), .got(got),
        .rd_data(rd_data0), .valid(valid0), .fill_lvl(fill0)
    );

    function automatic int lvl(int n);
        int c = (n * (1 << BITS)) / DEPTH;
        return (c > (1 << BITS) - 1) ? (1 << BITS) - 1 : c;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all();
        chk("R4 valid", int'(valid), int'(mcmt != mrd));
        chk("R6 full", int'(full), int'((mtmp - mrd) == DEPTH));
        chk("R8 fill_lvl", int'(fill_lvl), lvl(mcmt - mrd));
        chk("R9 space_lvl", int'(space_lvl), lvl(DEPTH - (mtmp - mrd)));
        if (mcmt != mrd) chk("R10 rd_data", int'(rd_data), int'(mmem[mrd % DEPTH]));
        chk("R11 zero-width levels", int'({space0, fill0}), 0);
    endtask

    task automatic step(bit p, bit c, bit r, bit g, logic [7:0] d);
        bit mp, mg;
        put = p; commit = c; rollback = r; got = g; wr_data = d;
        mp = p && ((mtmp - mrd) < DEPTH);
        mg = g && (mcmt != mrd);
        @(posedge clk);
        if (mp) begin mmem[mtmp % DEPTH] = d; mtmp++; end
        if (mg) mrd++;
        if (c) mcmt = mtmp;
        else if (r) mtmp = mcmt;
        @(negedge clk);
        put = 0; commit = 0; rollback = 0; got = 0;
        check_all();
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 valid", int'(valid), 0);
        chk("R1 full", int'(full), 0);
        chk("R1 fill_lvl", int'(fill_lvl), 0);
        chk("R1 space_lvl", int'(space_lvl), 3);
        // R7 got on empty
        step(0, 0, 0, 1, 8'h00);
        chk("R7 valid after empty got", int'(valid), 0);
        // R2/R3 fill with provisional words
        for (int i = 0; i < 15; i++) step(1, 0, 0, 0, 8'(8'h10 + i));
        chk("R2 not full after 15", int'(full), 0);
        step(1, 0, 0, 0, 8'h1F);
        chk("R2 full after 16", int'(full), 1);
        chk("R3 not valid while full", int'(valid), 0);
        // R6 put while full
        step(1, 0, 0, 0, 8'hEE);
        chk("R6 still full", int'(full), 1);
        // R5 rollback frees space
        step(0, 0, 1, 0, 8'h00);
        chk("R5 full cleared", int'(full), 0);
        chk("R5 space max", int'(space_lvl), 3);
        chk("R5 nothing readable", int'(valid), 0);
        // R4 commit with same-cycle put
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 8'(8'h40 + i));
        step(1, 1, 0, 0, 8'h43);
        chk("R4 fill after commit", int'(fill_lvl), 1);
        // R5 rollback with same-cycle put keeps committed words
        step(1, 0, 0, 0, 8'h77);
        step(1, 0, 1, 0, 8'h78);
        chk("R5 space after rollback", int'(space_lvl), 3);
        // R10 read in order
        for (int i = 0; i < 4; i++) begin
            chk("R10 order", int'(rd_data), 8'h40 + i);
            step(0, 0, 0, 1, 8'h00);
        end
        chk("R7 empty after drain", int'(valid), 0);
        // random traffic
        void'($urandom(32'd1234));
        for (int i = 0; i < 3000; i++) begin
            int rc = $urandom_range(99);
            step($urandom_range(99) < 55, rc < 8, rc >= 8 && rc < 12,
                 $urandom_range(99) < 40, 8'($urandom));
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule